// File: doc/BRIEF.md
# PCIe Function Error Signaling Unit

This block sits beside a single PCIe function and handles every error that the function detects. It takes at most one error event per clock. Each event carries a one-hot error code, a flag marking it correctable, a flag marking it as possibly advisory, and the requester ID of the source. For each event the block decides which device-status and error-status bits to set, whether the header logger must capture the event, and whether an error message goes upstream with a severity of correctable, non-fatal or fatal.

The configuration comes in on plain inputs: the system-error enable from the command register, four reporting enables from device control, the uncorrectable mask and severity vectors, a flag that selects the programmed severity vector over the built-in defaults, and the correctable mask. The status registers are held inside the block. Software clears them with a write-one-to-clear port.

The header logger answers the record strobe in the same cycle. If it reports an overflow, the block spends the next cycle on a follow-on correctable header-log-overflow error. During that cycle it raises `busy` and ignores the event inputs.

Top module: `pcie_err_signal`

## Requirements
- R1: An event whose code, after masking to the supported set, has zero bits or more than one bit set is rejected. It changes no status, pulses no record strobe and sends no message. The supported uncorrectable bits are 4, 5 and 12 to 25. The supported correctable bits are 0, 6, 7, 8 and 12 to 15.
- R2: An uncorrectable error is fatal by default for bits 4, 5, 13, 17, 18 and 22, and non-fatal for every other supported bit. When `sev_prog_en` is 1, the bit in `unc_sev` decides instead (1 = fatal).
- R3: `dev_sta` bit 0 marks correctable-detected, bit 1 non-fatal-detected, bit 2 fatal-detected and bit 3 unsupported-request-detected. An accepted uncorrectable error sets bit 2 or bit 1 according to its severity.
- R4: An uncorrectable error whose `unc_mask` bit is set only sets its `unc_sta` bit. It causes no record strobe and no message.
- R5: An unmasked uncorrectable error raises `rec_stb` combinationally in its own cycle and sets its `unc_sta` bit. A message is sent when `cmd_serr_en` is 1, or when the enable for its severity (`rpt_fatal_en` or `rpt_nonfatal_en`) is 1.
- R6: The unsupported-request error is uncorrectable bit 20, and it sets `dev_sta` bit 3. On the uncorrectable path its message is dropped when both `rpt_ur_en` and `cmd_serr_en` are 0. On the advisory path its message is dropped whenever `rpt_ur_en` is 0.
- R7: A correctable error sets `dev_sta` bit 0 and its `cor_sta` bit. A message goes out only when its `cor_mask` bit is 0 and `rpt_cor_en` is 1.
- R8: A non-fatal uncorrectable error with `ev_advisory` set becomes the advisory correctable error, which is `cor_sta` bit 13. It is handled as R7 describes. If that bit is not masked, the original `unc_sta` bit is also set, and the event is recorded only when its `unc_mask` bit is 0.
- R9: When `rec_stb` and `rec_ovf` are both 1, the next cycle has `busy` at 1. In that cycle the block ignores the event inputs and processes correctable bit 15 with source ID 0.
- R10: When `wr_en` is 1, each bit set in `wr_data` clears the matching bit of the register chosen by `wr_sel`: 0 selects `dev_sta`, 1 selects `unc_sta`, 2 selects `cor_sta`. A bit that an event sets in the same cycle stays set.
- R11: After reset, every status register, `busy` and the message outputs are zero.
- R12: A message appears as a one-cycle `msg_valid` pulse in the cycle after the event. It carries `msg_sev` (1 correctable, 2 non-fatal, 3 fatal) and `msg_src`. Both fields are zero while `msg_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Error event present |
| ev_code | input | 32 | One-hot error code |
| ev_corr | input | 1 | Event is correctable |
| ev_advisory | input | 1 | Non-fatal event may be advisory |
| ev_src | input | 16 | Requester ID of the source |
| cmd_serr_en | input | 1 | System-error enable from command register |
| rpt_cor_en | input | 1 | Correctable reporting enable |
| rpt_nonfatal_en | input | 1 | Non-fatal reporting enable |
| rpt_fatal_en | input | 1 | Fatal reporting enable |
| rpt_ur_en | input | 1 | Unsupported-request reporting enable |
| sev_prog_en | input | 1 | Use unc_sev instead of default severities |
| unc_mask | input | 32 | Uncorrectable mask |
| unc_sev | input | 32 | Uncorrectable severity (1 = fatal) |
| cor_mask | input | 32 | Correctable mask |
| rec_stb | output | 1 | Logger must capture this event |
| rec_ovf | input | 1 | Logger overflow reply to rec_stb |
| wr_en | input | 1 | Status clear write |
| wr_sel | input | 2 | Register chosen for the clear |
| wr_data | input | 32 | Write-one-to-clear data |
| busy | output | 1 | Follow-on overflow event in progress |
| dev_sta | output | 4 | Device status bits |
| unc_sta | output | 32 | Uncorrectable error status |
| cor_sta | output | 32 | Correctable error status |
| msg_valid | output | 1 | Upstream message pulse |
| msg_sev | output | 2 | Message severity |
| msg_src | output | 16 | Message source ID |

## Verification
The hardest situation to reach is the follow-on overflow event. It needs an unmasked uncorrectable or advisory error that records, together with an overflow reply in the same cycle, and then a busy cycle in which a live event arrives and must be ignored. The random stimulus drives `rec_ovf` about a third of the time and keeps masks sparse, so recording events are common and overflow follow-ons occur many times with events pending behind them. Directed cases also cover the advisory downgrade with a masked advisory bit, and the unsupported-request gating with both enables clear.

// File: rtl/pes_pkg.sv
package pes_pkg;
  localparam int CODE_W = 32;
  localparam int DS_W   = 4;

  localparam logic [CODE_W-1:0] UNC_SUPPORTED  = 32'h03FF_F030;
  localparam logic [CODE_W-1:0] UNC_FATAL_DFLT = 32'h0046_2030;
  localparam logic [CODE_W-1:0] COR_SUPPORTED  = 32'h0000_F1C1;

  localparam int UR_BIT  = 20;
  localparam int ADV_BIT = 13;
  localparam int HLO_BIT = 15;

  localparam int DS_COR = 0;
  localparam int DS_NF  = 1;
  localparam int DS_FAT = 2;
  localparam int DS_UR  = 3;

  typedef enum logic [1:0] {
    SEV_NONE     = 2'd0,
    SEV_COR      = 2'd1,
    SEV_NONFATAL = 2'd2,
    SEV_FATAL    = 2'd3
  } sev_e;

  function automatic logic single_bit(input logic [CODE_W-1:0] v);
    return (v != '0) && ((v & (v - CODE_W'(1))) == '0);
  endfunction

  function automatic logic [CODE_W-1:0] w1c_next(
      input logic [CODE_W-1:0] q, input logic [CODE_W-1:0] set_v,
      input logic clr_en, input logic [CODE_W-1:0] clr_v);
    logic [CODE_W-1:0] keep;
    keep = clr_en ? (q & ~clr_v) : q;
    return keep | set_v;
  endfunction
endpackage

// File: rtl/pes_classify.sv
module pes_classify import pes_pkg::*; (
  input  logic              take,
  input  logic [CODE_W-1:0] code,
  input  logic              corr,
  input  logic              adv,
  input  logic              sev_prog_en,
  input  logic [CODE_W-1:0] unc_sev,
  output logic              code_ok,
  output logic [CODE_W-1:0] sel_code,
  output logic              is_ur,
  output logic              is_fatal,
  output logic              cor_path,
  output logic              adv_path,
  output logic              unc_path
);
  logic [CODE_W-1:0] sev_src;

  always_comb begin
    sel_code = code & (corr ? COR_SUPPORTED : UNC_SUPPORTED);
    code_ok  = take && single_bit(sel_code);
    is_ur    = !corr && (sel_code == (CODE_W'(1) << UR_BIT));
    sev_src  = sev_prog_en ? unc_sev : UNC_FATAL_DFLT;
    is_fatal = !corr && ((sev_src & sel_code) != '0);
    cor_path = code_ok && corr;
    adv_path = code_ok && !corr && !is_fatal && adv;
    unc_path = code_ok && !corr && !adv_path;
  end
endmodule

// File: rtl/pes_decide.sv
module pes_decide import pes_pkg::*; (
  input  logic              cor_path,
  input  logic              adv_path,
  input  logic              unc_path,
  input  logic              is_ur,
  input  logic              is_fatal,
  input  logic [CODE_W-1:0] sel_code,
  input  logic [CODE_W-1:0] unc_mask,
  input  logic [CODE_W-1:0] cor_mask,
  input  logic              cmd_serr_en,
  input  logic              rpt_cor_en,
  input  logic              rpt_nonfatal_en,
  input  logic              rpt_fatal_en,
  input  logic              rpt_ur_en,
  output logic [DS_W-1:0]   ds_set,
  output logic [CODE_W-1:0] unc_set,
  output logic [CODE_W-1:0] cor_set,
  output logic              rec,
  output logic              send,
  output sev_e              sev
);
  logic [CODE_W-1:0] cor_code;
  logic              cor_masked, unc_masked, sev_en;

  always_comb begin
    cor_code   = adv_path ? (CODE_W'(1) << ADV_BIT) : sel_code;
    cor_masked = (cor_mask & cor_code) != '0;
    unc_masked = (unc_mask & sel_code) != '0;
    sev_en     = is_fatal ? rpt_fatal_en : rpt_nonfatal_en;
    ds_set  = '0;
    unc_set = '0;
    cor_set = '0;
    rec     = 1'b0;
    send    = 1'b0;
    sev     = SEV_NONE;
    if (cor_path || adv_path) begin
      ds_set[DS_COR] = 1'b1;
      ds_set[DS_UR]  = is_ur;
      cor_set        = cor_code;
      if (!cor_masked) begin
        if (adv_path) begin
          unc_set = sel_code;
          rec     = !unc_masked;
        end
        send = rpt_cor_en && !(is_ur && !rpt_ur_en);
        sev  = SEV_COR;
      end
    end else if (unc_path) begin
      ds_set[DS_FAT] = is_fatal;
      ds_set[DS_NF]  = !is_fatal;
      ds_set[DS_UR]  = is_ur;
      unc_set        = sel_code;
      if (!unc_masked) begin
        rec  = 1'b1;
        send = (cmd_serr_en || sev_en) &&
               !(is_ur && !rpt_ur_en && !cmd_serr_en);
        sev  = is_fatal ? SEV_FATAL : SEV_NONFATAL;
      end
    end
  end
endmodule

// File: rtl/pes_state.sv
module pes_state import pes_pkg::*; #(
  parameter int SRC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DS_W-1:0]   ds_set,
  input  logic [CODE_W-1:0] unc_set,
  input  logic [CODE_W-1:0] cor_set,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              send,
  input  sev_e              sev,
  input  logic [SRC_W-1:0]  src,
  input  logic              ovf_evt,
  output logic              pend_q,
  output logic [DS_W-1:0]   dev_sta,
  output logic [CODE_W-1:0] unc_sta,
  output logic [CODE_W-1:0] cor_sta,
  output logic              msg_valid,
  output logic [1:0]        msg_sev,
  output logic [SRC_W-1:0]  msg_src
);
  localparam int NREG = 3;

  logic [NREG-1:0]   clr_hit;
  logic [CODE_W-1:0] ds_wide, ds_next;

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign clr_hit[g] = wr_en && (wr_sel == 2'(g));
  end

  assign ds_wide = CODE_W'(dev_sta);
  assign ds_next = w1c_next(ds_wide, CODE_W'(ds_set), clr_hit[0], wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_sta   <= '0;
      unc_sta   <= '0;
      cor_sta   <= '0;
      pend_q    <= 1'b0;
      msg_valid <= 1'b0;
      msg_sev   <= '0;
      msg_src   <= '0;
    end else begin
      dev_sta   <= ds_next[DS_W-1:0];
      unc_sta   <= w1c_next(unc_sta, unc_set, clr_hit[1], wr_data);
      cor_sta   <= w1c_next(cor_sta, cor_set, clr_hit[2], wr_data);
      pend_q    <= ovf_evt;
      msg_valid <= send;
      msg_sev   <= send ? sev : SEV_NONE;
      msg_src   <= send ? src : '0;
    end
  end
endmodule

// File: rtl/pcie_err_signal.sv
module pcie_err_signal import pes_pkg::*; #(
  parameter int SRC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [CODE_W-1:0] ev_code,
  input  logic              ev_corr,
  input  logic              ev_advisory,
  input  logic [SRC_W-1:0]  ev_src,
  input  logic              cmd_serr_en,
  input  logic              rpt_cor_en,
  input  logic              rpt_nonfatal_en,
  input  logic              rpt_fatal_en,
  input  logic              rpt_ur_en,
  input  logic              sev_prog_en,
  input  logic [CODE_W-1:0] unc_mask,
  input  logic [CODE_W-1:0] unc_sev,
  input  logic [CODE_W-1:0] cor_mask,
  output logic              rec_stb,
  input  logic              rec_ovf,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CODE_W-1:0] wr_data,
  output logic              busy,
  output logic [DS_W-1:0]   dev_sta,
  output logic [CODE_W-1:0] unc_sta,
  output logic [CODE_W-1:0] cor_sta,
  output logic              msg_valid,
  output logic [1:0]        msg_sev,
  output logic [SRC_W-1:0]  msg_src
);
  logic              pend_q;
  logic              f_take, f_corr, f_adv;
  logic [CODE_W-1:0] f_code;
  logic [SRC_W-1:0]  f_src;

  logic              code_ok, is_ur, is_fatal, cor_path, adv_path, unc_path;
  logic [CODE_W-1:0] sel_code;
  logic [DS_W-1:0]   ds_set;
  logic [CODE_W-1:0] unc_set, cor_set;
  logic              rec, send, ovf_evt;
  sev_e              sev;

  always_comb begin
    f_take = pend_q || ev_valid;
    f_code = pend_q ? (CODE_W'(1) << HLO_BIT) : ev_code;
    f_corr = pend_q || ev_corr;
    f_adv  = !pend_q && ev_advisory;
    f_src  = pend_q ? '0 : ev_src;
  end

  pes_classify u_cls (
    .take(f_take), .code(f_code), .corr(f_corr), .adv(f_adv),
    .sev_prog_en(sev_prog_en), .unc_sev(unc_sev),
    .code_ok(code_ok), .sel_code(sel_code), .is_ur(is_ur),
    .is_fatal(is_fatal), .cor_path(cor_path), .adv_path(adv_path),
    .unc_path(unc_path)
  );

  pes_decide u_dec (
    .cor_path(cor_path), .adv_path(adv_path), .unc_path(unc_path),
    .is_ur(is_ur), .is_fatal(is_fatal), .sel_code(sel_code),
    .unc_mask(unc_mask), .cor_mask(cor_mask),
    .cmd_serr_en(cmd_serr_en), .rpt_cor_en(rpt_cor_en),
    .rpt_nonfatal_en(rpt_nonfatal_en), .rpt_fatal_en(rpt_fatal_en),
    .rpt_ur_en(rpt_ur_en),
    .ds_set(ds_set), .unc_set(unc_set), .cor_set(cor_set),
    .rec(rec), .send(send), .sev(sev)
  );

  assign rec_stb = rec;
  assign ovf_evt = rec && rec_ovf;
  assign busy    = pend_q;

  pes_state #(.SRC_W(SRC_W)) u_st (
    .clk(clk), .rst_n(rst_n),
    .ds_set(ds_set), .unc_set(unc_set), .cor_set(cor_set),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .send(send), .sev(sev), .src(f_src), .ovf_evt(ovf_evt),
    .pend_q(pend_q), .dev_sta(dev_sta), .unc_sta(unc_sta),
    .cor_sta(cor_sta), .msg_valid(msg_valid), .msg_sev(msg_sev),
    .msg_src(msg_src)
  );
endmodule

// File: rtl/pes_checker.sv
module pes_checker import pes_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic              busy,
  input logic              code_ok,
  input logic              unc_path,
  input logic              cor_path,
  input logic              adv_path,
  input logic [CODE_W-1:0] sel_code,
  input logic [CODE_W-1:0] unc_mask,
  input logic              rec_stb,
  input logic              rec_ovf,
  input logic              send,
  input logic              wr_en,
  input logic [3:0]        dev_sta,
  input logic [CODE_W-1:0] unc_sta,
  input logic [CODE_W-1:0] cor_sta,
  input logic              msg_valid,
  input logic [1:0]        msg_sev
);
  a_r1_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !busy && !code_ok && !wr_en) |=>
      ($stable(unc_sta) && $stable(cor_sta) && $stable(dev_sta) &&
       !msg_valid && !busy));

  a_r1_no_record: assert property (@(posedge clk) disable iff (!rst_n)
    !code_ok |-> !rec_stb);

  a_r4_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (unc_path && ((unc_mask & sel_code) != '0)) |=> !msg_valid);

  a_r5_record_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_stb && !wr_en) |=> ((unc_sta & $past(sel_code)) != '0));

  a_r7_cor_severity: assert property (@(posedge clk) disable iff (!rst_n)
    ((cor_path || adv_path) && send) |=> (msg_sev == SEV_COR));

  a_r9_followon: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_stb && rec_ovf) |=> busy);

  a_r9_single_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  a_r12_sev_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_sev != SEV_NONE));
endmodule

bind pcie_err_signal pes_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .busy(busy),
  .code_ok(code_ok), .unc_path(unc_path), .cor_path(cor_path),
  .adv_path(adv_path), .sel_code(sel_code), .unc_mask(unc_mask),
  .rec_stb(rec_stb), .rec_ovf(rec_ovf), .send(send), .wr_en(wr_en),
  .dev_sta(dev_sta), .unc_sta(unc_sta), .cor_sta(cor_sta),
  .msg_valid(msg_valid), .msg_sev(msg_sev)
);

// File: tb/pcie_err_signal_bench.sv
`timescale 1ns/1ps
module pcie_err_signal_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        ev_valid, ev_corr, ev_advisory;
  logic [31:0] ev_code;
  logic [15:0] ev_src;
  logic        cmd_serr_en, rpt_cor_en, rpt_nonfatal_en, rpt_fatal_en, rpt_ur_en;
  logic        sev_prog_en;
  logic [31:0] unc_mask, unc_sev, cor_mask;
  logic        rec_stb, rec_ovf, wr_en, busy;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [3:0]  dev_sta;
  logic [31:0] unc_sta, cor_sta;
  logic        msg_valid;
  logic [1:0]  msg_sev;
  logic [15:0] msg_src;

  pcie_err_signal u_pcie_err_signal (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
    .ev_corr(ev_corr), .ev_advisory(ev_advisory), .ev_src(ev_src),
    .cmd_serr_en(cmd_serr_en), .rpt_cor_en(rpt_cor_en),
    .rpt_nonfatal_en(rpt_nonfatal_en), .rpt_fatal_en(rpt_fatal_en),
    .rpt_ur_en(rpt_ur_en), .sev_prog_en(sev_prog_en),
    .unc_mask(unc_mask), .unc_sev(unc_sev), .cor_mask(cor_mask),
    .rec_stb(rec_stb), .rec_ovf(rec_ovf), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .busy(busy), .dev_sta(dev_sta), .unc_sta(unc_sta),
    .cor_sta(cor_sta), .msg_valid(msg_valid), .msg_sev(msg_sev),
    .msg_src(msg_src)
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference state
  logic [3:0]  m_ds;
  logic [31:0] m_unc, m_cor;
  logic        m_pend;
  logic [3:0]  e_ds;
  logic [31:0] e_unc, e_cor;
  logic        e_rec, e_send;
  logic [1:0]  e_sev;
  logic [15:0] e_src;

  function automatic bit supported(bit c, int i);
    if (c) return (i == 0 || i == 6 || i == 7 || i == 8 || (i >= 12 && i <= 15));
    return (i == 4 || i == 5 || (i >= 12 && i <= 25));
  endfunction

  function automatic bit dflt_fatal(int i);
    case (i)
      4, 5, 13, 17, 18, 22: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_eval();
    logic v, c, a;
    logic [31:0] code, cm;
    int idx;
    bit fatal, ur;
    e_ds = 0; e_unc = 0; e_cor = 0; e_rec = 0; e_send = 0; e_sev = 0;
    if (m_pend) begin
      v = 1; code = 32'h0000_8000; c = 1; a = 0; e_src = 16'h0;
    end else begin
      v = ev_valid; code = ev_code; c = ev_corr; a = ev_advisory; e_src = ev_src;
    end
    if (!v) return;
    cm = 0;
    idx = 0;
    for (int i = 0; i < 32; i++) if (code[i] && supported(c, i)) begin cm[i] = 1'b1; idx = i; end
    if ($countones(cm) != 1) return;
    if (c) begin
      e_ds[0] = 1; e_cor[idx] = 1;
      if (!cor_mask[idx]) begin e_send = rpt_cor_en; e_sev = 2'd1; end
    end else begin
      ur = (idx == 20);
      fatal = sev_prog_en ? unc_sev[idx] : dflt_fatal(idx);
      if (!fatal && a) begin
        e_ds[0] = 1; e_ds[3] = ur; e_cor[13] = 1;
        if (!cor_mask[13]) begin
          e_unc[idx] = 1;
          e_rec = !unc_mask[idx];
          e_send = rpt_cor_en && !(ur && !rpt_ur_en);
          e_sev = 2'd1;
        end
      end else begin
        if (fatal) e_ds[2] = 1; else e_ds[1] = 1;
        e_ds[3] = ur; e_unc[idx] = 1;
        if (!unc_mask[idx]) begin
          e_rec = 1;
          e_send = (cmd_serr_en || (fatal ? rpt_fatal_en : rpt_nonfatal_en)) &&
                   !(ur && !rpt_ur_en && !cmd_serr_en);
          e_sev = fatal ? 2'd3 : 2'd2;
        end
      end
    end
  endtask

  task automatic cycle();
    logic nxt_pend;
    #1;
    model_eval();
    check("R5 rec_stb", 32'(rec_stb), 32'(e_rec));
    check("R9 busy", 32'(busy), 32'(m_pend));
    nxt_pend = e_rec && rec_ovf;
    if (wr_en) begin
      if (wr_sel == 2'd0) m_ds  = m_ds & ~wr_data[3:0];
      if (wr_sel == 2'd1) m_unc = m_unc & ~wr_data;
      if (wr_sel == 2'd2) m_cor = m_cor & ~wr_data;
    end
    m_ds = m_ds | e_ds; m_unc = m_unc | e_unc; m_cor = m_cor | e_cor;
    m_pend = nxt_pend;
    @(posedge clk);
    #1;
    check("R3 dev_sta", 32'(dev_sta), 32'(m_ds));
    check("R4 unc_sta", unc_sta, m_unc);
    check("R7 cor_sta", cor_sta, m_cor);
    check("R12 msg_valid", 32'(msg_valid), 32'(e_send));
    check("R12 msg_sev", 32'(msg_sev), e_send ? 32'(e_sev) : 32'h0);
    check("R12 msg_src", 32'(msg_src), e_send ? 32'(e_src) : 32'h0);
  endtask

  task automatic quiet_cfg();
    ev_valid = 0; ev_code = 0; ev_corr = 0; ev_advisory = 0; ev_src = 0;
    cmd_serr_en = 0; rpt_cor_en = 1; rpt_nonfatal_en = 1; rpt_fatal_en = 1;
    rpt_ur_en = 1; sev_prog_en = 0; unc_mask = 0; unc_sev = 0; cor_mask = 0;
    rec_ovf = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
  endtask

  task automatic ev(logic [31:0] code, logic c, logic a, logic [15:0] s);
    ev_valid = 1; ev_code = code; ev_corr = c; ev_advisory = a; ev_src = s;
  endtask

  task automatic clear_all();
    quiet_cfg();
    wr_en = 1; wr_data = 32'hFFFF_FFFF;
    for (int k = 0; k < 3; k++) begin wr_sel = 2'(k); cycle(); end
    wr_en = 0;
  endtask

  initial begin : watchdog
    #3_000_000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    quiet_cfg();
    m_ds = 0; m_unc = 0; m_cor = 0; m_pend = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset dev_sta", 32'(dev_sta), 0);
    check("R11 reset unc_sta", unc_sta, 0);
    check("R11 reset cor_sta", cor_sta, 0);
    check("R11 reset busy/msg", {busy, msg_valid, msg_sev, msg_src}, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R1: two bits, and unsupported-only bit
    ev(32'h0000_0030, 0, 0, 16'h1111); cycle();
    check("R1 two-bit rejected", {unc_sta[5:4], 2'b0, dev_sta}, 0);
    ev(32'h0000_0002, 1, 0, 16'h1111); cycle();
    check("R1 unsupported rejected", cor_sta | 32'(msg_valid), 0);
    quiet_cfg(); cycle();

    // R2: default fatal (bit 18), and override to non-fatal
    ev(32'h0004_0000, 0, 0, 16'hA001); cycle();
    check("R2 default fatal sev", 32'(msg_sev), 3);
    quiet_cfg(); sev_prog_en = 1; unc_sev = 0;
    ev(32'h0004_0000, 0, 0, 16'hA002); cycle();
    check("R2 programmed non-fatal sev", 32'(msg_sev), 2);
    clear_all();

    // R4: masked uncorrectable
    unc_mask = 32'h0000_1000; ev(32'h0000_1000, 0, 0, 16'hB000); cycle();
    check("R4 masked no msg", 32'(msg_valid), 0);
    clear_all();

    // R6: UR with both gates clear -> no msg, UR status set
    rpt_ur_en = 0; cmd_serr_en = 0; ev(32'h0010_0000, 0, 0, 16'hC000); cycle();
    check("R6 UR suppressed", 32'(msg_valid), 0);
    check("R6 UR detected", 32'(dev_sta[3]), 1);
    clear_all();

    // R8: advisory with masked advisory bit
    cor_mask = 32'h0000_2000; ev(32'h0000_1000, 0, 1, 16'hD000); cycle();
    check("R8 masked advisory leaves unc_sta", unc_sta, 0);
    quiet_cfg(); ev(32'h0000_1000, 0, 1, 16'hD001); cycle();
    check("R8 advisory correctable msg", {msg_valid, msg_sev}, 3'b101);
    clear_all();

    // R9: overflow follow-on, live event ignored while busy
    ev(32'h0000_1000, 0, 0, 16'hE000); rec_ovf = 1; cycle();
    rec_ovf = 0; ev(32'h0000_4000, 0, 0, 16'hE001); cycle();
    check("R9 follow-on sets hdr overflow", 32'(cor_sta[15]), 1);
    check("R9 busy event ignored", 32'(unc_sta[14]), 0);
    check("R9 follow-on src zero", 32'(msg_src), 0);
    quiet_cfg(); cycle();

    // R10: set wins over clear in the same cycle
    wr_en = 1; wr_sel = 2; wr_data = 32'hFFFF_FFFF; ev(32'h0000_0001, 1, 0, 16'hF000); cycle();
    check("R10 set beats clear", 32'(cor_sta[0]), 1);
    quiet_cfg(); cycle();

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      ev_valid = ($urandom_range(0, 9) < 8);
      case ($urandom_range(0, 9))
        0: ev_code = 32'h0;
        1: ev_code = (32'h1 << $urandom_range(0, 31)) | (32'h1 << $urandom_range(0, 31));
        default: ev_code = 32'h1 << $urandom_range(0, 31);
      endcase
      ev_corr = r[0]; ev_advisory = r[1]; ev_src = 16'($urandom);
      cmd_serr_en = r[2]; rpt_cor_en = r[3] | r[4]; rpt_nonfatal_en = r[5];
      rpt_fatal_en = r[6] | r[7]; rpt_ur_en = r[8]; sev_prog_en = r[9];
      unc_mask = $urandom & $urandom & $urandom;
      unc_sev = $urandom;
      cor_mask = $urandom & $urandom & $urandom;
      rec_ovf = ($urandom_range(0, 2) == 0);
      wr_en = ($urandom_range(0, 4) == 0);
      wr_sel = 2'($urandom);
      wr_data = $urandom & $urandom;
      cycle();
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule